// File: doc/BRIEF.md
# Sound Coprocessor Interval Timer Unit

This block provides three interval timers for an 8-bit sound coprocessor. Each timer holds an 8-bit divisor and a hidden 8-bit remaining-count. On each tick the timer is allowed to take, the remaining-count steps down by one. When it reaches zero, the timer's 4-bit event counter goes up by one and the remaining-count is refilled from the divisor. Timers 0 and 1 step on a slow tick enable of 8 kHz. Timer 2 steps on a fast tick enable of 64 kHz, which comes eight times as often. Both tick enables come from a prescaler outside this block.

Software programs the unit through a byte-wide register write port. One control register carries a run bit for each timer. Three write-only divisor registers set the periods. Software polls the three event counters through a read port. Reading a counter returns its value and clears it. This lets firmware count the periods that have elapsed since its last look.

Top module: `snd_timer_block`

## Requirements
- R1: Reset clears every event counter, every divisor and every run bit. After reset, reads of 0xFD, 0xFE and 0xFF return 0, and a divisor left at its reset value gives a period of 256 ticks.
- R2: A write to address 0xF1 sets the run bits from data bits 0, 1 and 2, which belong to timers 0, 1 and 2. A timer whose run bit is clear does not count.
- R3: Timers 0 and 1 step only on `tick_slow`. Timer 2 steps only on `tick_fast`.
- R4: With divisor N (1..255), the event counter goes up once every N steps. Divisor 0 gives a period of 256 steps. At terminal count the remaining-count is refilled from the divisor that was stored before that cycle.
- R5: Addresses 0xFA, 0xFB and 0xFC write the divisors of timers 0, 1 and 2. If the remaining-count is zero and no step happens in that cycle, the write also loads the remaining-count. Otherwise the new divisor takes effect only at the next terminal count.
- R6: In the cycle `rd_en` is high, a read of 0xFD, 0xFE or 0xFF returns the event counter of timer 0, 1 or 2 in bits 3:0, with bits 7:4 zero. The counter is 0 from the next cycle.
- R7: The 4-bit event counter wraps from 15 to 0.
- R8: If a read of a counter and that counter's increment fall in the same cycle, the read returns the old value and the counter becomes 1.
- R9: Clearing a run bit freezes that timer's remaining-count and event counter. Setting it again resumes from the frozen values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | 8 kHz step enable for timers 0 and 1, one clock wide |
| tick_fast | input | 1 | 64 kHz step enable for timer 2, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe, which clears the counter it addresses |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |

## Verification
The hardest case to reach from the ports is a timer resuming from a frozen, partly used remaining-count. The ports give no way to see that count. The stimulus therefore stops timer 0 two steps before its terminal count and runs timer 2 alone for a while. It then restarts timer 0 and shows that two steps, not a full period, bring the next event. The same reasoning drives the divisor-rewrite case: the divisor is changed while the remaining-count is not zero, and the old period must finish first. The read-versus-increment collision is reached by setting timer 2's divisor to 1, so that every fast tick is a terminal count, and then issuing the read in a cycle that carries a fast tick.

// File: rtl/snd_timer_block.sv
module snd_timer_block #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 4,
  parameter int FAST_IDX = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF1,
  parameter logic [ADDR_W-1:0] DIV_BASE  = 8'hFA,
  parameter logic [ADDR_W-1:0] CNT_BASE  = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DIV_W-1:0]  rd_data
);
  localparam int NT = 3;

  logic [NT-1:0]    run_q;
  logic [DIV_W-1:0] div_q [NT];
  logic [DIV_W-1:0] rem_q [NT];
  logic [CNT_W-1:0] cnt_q [NT];
  logic [NT-1:0]    step_w, term_w, div_hit, rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_q <= '0;
    else if (wr_en && wr_addr == CTRL_ADDR)
      run_q <= wr_data[NT-1:0];
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    assign step_w[g]  = run_q[g] & ((g == FAST_IDX) ? tick_fast : tick_slow);
    assign term_w[g]  = step_w[g] && rem_q[g] == DIV_W'(1);
    assign div_hit[g] = wr_en && wr_addr == DIV_BASE + ADDR_W'(g);
    assign rd_hit[g]  = rd_en && rd_addr == CNT_BASE + ADDR_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        div_q[g] <= '0;
        rem_q[g] <= '0;
        cnt_q[g] <= '0;
      end else begin
        if (div_hit[g])
          div_q[g] <= wr_data;
        if (step_w[g])
          rem_q[g] <= term_w[g] ? div_q[g] : rem_q[g] - DIV_W'(1);
        else if (div_hit[g] && rem_q[g] == '0)
          rem_q[g] <= wr_data;
        if (term_w[g])
          cnt_q[g] <= rd_hit[g] ? CNT_W'(1) : cnt_q[g] + CNT_W'(1);
        else if (rd_hit[g])
          cnt_q[g] <= '0;
      end
    end

    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      term_w[g] |=> rem_q[g] == $past(div_q[g])); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[g] && !rd_hit[g] && !div_hit[g]) |=> ($stable(cnt_q[g]) && $stable(rem_q[g]))); // R9
    AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_w[g] && !div_hit[g]) |=> $stable(rem_q[g])); // R3
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (div_hit[g] && !step_w[g] && rem_q[g] == '0) |=> rem_q[g] == $past(wr_data)); // R5
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[g] && !term_w[g]) |=> cnt_q[g] == '0); // R6
    AST_RD_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[g] && term_w[g]) |=> cnt_q[g] == CNT_W'(1)); // R8
    AST_CNT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] != $past(cnt_q[g])) |->
        (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1) || cnt_q[g] == '0 || cnt_q[g] == CNT_W'(1))); // R7
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NT; i++)
      if (rd_hit[i])
        rd_data = {{(DIV_W-CNT_W){1'b0}}, cnt_q[i]};
  end

  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit)); // R6
endmodule

// File: tb/snd_timer_block_tb.sv
module snd_timer_block_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'hF1, A_D0 = 8'hFA, A_D1 = 8'hFB, A_D2 = 8'hFC;
  localparam logic [7:0] A_C0 = 8'hFD, A_C1 = 8'hFE, A_C2 = 8'hFF;

  logic clk = 0, rst_n = 0;
  logic tick_slow = 0, tick_fast = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_timer_block dut_i (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic cyc(input logic ts, input logic tf, input logic we, input logic [7:0] wa,
                     input logic [7:0] wd, input logic re, input logic [7:0] ra,
                     input logic [7:0] ev, input string tg);
    @(posedge clk); #1;
    tick_slow = ts; tick_fast = tf; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re) begin exp_q.push_back(ev); tag_q.push_back(tg); end
  endtask

  task automatic idle();               cyc(0, 0, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(0, 0, 1, a, d, 0, 0, 0, ""); endtask
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t); cyc(0, 0, 0, 0, 0, 1, a, e, t); endtask
  task automatic slow(input int n); for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic fast(input int n); for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0, ""); endtask

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s addr=%h got=%h exp=%h", t, rd_addr, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(A_C0, 0, "R1"); rd(A_C1, 0, "R1"); rd(A_C2, 0, "R1");
    // R4/R5: divisor 3 loads zero remaining-count; 7 slow steps -> 2 events
    wr(A_D0, 3); wr(A_CTRL, 8'h01);
    slow(7);
    rd(A_C0, 2, "R4"); rd(A_C0, 0, "R6");
    // R2 timer 1 not running; R3 timer 0 ignores fast ticks
    rd(A_C1, 0, "R2");
    fast(4);
    rd(A_C0, 0, "R3");
    // R9 freeze timer 0 (two steps left); R3 timer 2 on fast ticks only
    wr(A_CTRL, 8'h04); wr(A_D2, 2);
    fast(6);
    rd(A_C2, 3, "R3");
    slow(4);
    rd(A_C2, 0, "R3"); rd(A_C0, 0, "R9");
    // R9 resume: two steps reach terminal count
    wr(A_CTRL, 8'h01);
    slow(2);
    rd(A_C0, 1, "R9");
    // R5 rewrite divisor while remaining-count is 3
    wr(A_D0, 5);
    slow(3);
    rd(A_C0, 1, "R5");
    slow(4);
    rd(A_C0, 0, "R5");
    slow(1);
    rd(A_C0, 1, "R5");
    // R1/R4 reset divisor 0 gives 256-step period on timer 1; R2 timer 0 stopped
    wr(A_CTRL, 8'h02);
    slow(255);
    rd(A_C1, 0, "R4");
    slow(1);
    rd(A_C1, 1, "R1"); rd(A_C0, 0, "R2");
    // R7 wrap: divisor 1 on timer 2 (remaining 2 -> one extra step first)
    wr(A_D2, 1); wr(A_CTRL, 8'h04);
    fast(17);
    rd(A_C2, 0, "R7");
    fast(1);
    rd(A_C2, 1, "R7");
    // R8 read collides with increment
    fast(2);
    cyc(0, 1, 0, 0, 0, 1, A_C2, 2, "R8");
    rd(A_C2, 1, "R8");
    idle(); idle();
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6 pending=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule